// File: doc/BRIEF.md
# Stepped AGC Gain Controller

This block is the digital sequencer of a receiver's automatic gain control loop. It steers the front end through a ladder of five paired LNA/filter gain codes, ordered from most to least gain. At each evaluation point it compares a 7-bit RSSI code against a low and a high threshold. If the signal is too weak it moves one rung toward more gain, and if it is too strong it moves one rung toward less gain. Otherwise it declares the loop settled. After every gain change it stays quiet for a programmable number of update ticks, so that front-end transients can die away before the next measurement.

Evaluation points come from an update tick. That tick is derived from a base sequencer clock enable, divided by a 6-bit programmable divider; a divider value of 13 is the usual choice. Threshold values of 30 and 70 suit most installations. When the loop is switched off, the gain outputs follow a manually written (LNA, filter) pair. The block also reports a live input power estimate in half-dB units, built from the RSSI code and the correction of the gain step currently applied.

Top module: `agc_stepper`

## Requirements
- R1: While reset is active and on the first cycle after it, the gains are LNA=2'b10 and filter=2'b10, `settled` is 0 and `step_count` is 0.
- R2: With the loop enabled, (LNA, filter) is always one rung of the ladder, ordered from index 0 (most gain) to index 4: (10,10), (01,10), (01,01), (01,00), (00,00).
- R3: On an evaluation, an RSSI code below `thr_lo` moves the ladder index one step toward 0 unless it is already 0. An RSSI code above `thr_hi` moves the index one step toward 4 unless it is already 4. A change appears on the cycle after the evaluation tick.
- R4: An evaluation that does not move the gain sets `settled` to 1. This includes a weak signal at index 0 and a strong signal at index 4. Every gain change clears `settled`.
- R5: After a gain change, the next `settle_ticks` update ticks only count down and do not evaluate. The tick after them evaluates.
- R6: An update tick occurs on a `seq_tick` cycle when the count of earlier `seq_tick` pulses since the last update reaches `agc_div`-1. An `agc_div` of 0 acts as 1.
- R7: `cfg_err` is 1 whenever `thr_hi` - `thr_lo` is 30 or less, taken as a signed difference. While it is 1, no evaluation takes place and the gain holds.
- R8: `power_hdb` equals `rssi_code` + correction - 260 as a signed value. The correction is 0, 24, 38, 58 or 86 for ladder index 0 to 4.
- R9: With `agc_en` low, the gains equal `man_lna`/`man_flt`. The correction is taken from the matching ladder pair, or 0 if the pair is not on the ladder. The loop state returns to index 0, with `settled` 0 and `step_count` 0, so re-enabling restarts from maximum gain.
- R10: `step_count` counts gain changes since the last restart and saturates at 4.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| seq_tick | input | 1 | Base sequencer clock enable |
| agc_div | input | 6 | Update tick divider (0 acts as 1) |
| settle_ticks | input | SET_W | Update ticks to wait after a gain change |
| agc_en | input | 1 | Loop enable; low selects manual gains |
| man_lna | input | 2 | Manual LNA gain code |
| man_flt | input | 2 | Manual filter gain code |
| thr_lo | input | 7 | Low RSSI threshold |
| thr_hi | input | 7 | High RSSI threshold |
| rssi_code | input | 7 | RSSI readback code |
| lna_gain | output | 2 | Applied LNA gain code |
| flt_gain | output | 2 | Applied filter gain code |
| settled | output | 1 | Loop has settled |
| cfg_err | output | 1 | Thresholds too close together |
| step_count | output | 3 | Gain changes since restart, saturating at 4 |
| power_hdb | output | 10 | Signed input power estimate in half-dB units |

## Verification
Two kinds of cycle overlap matter most. The first is a threshold rewrite that makes the pair invalid in the very cycle an update tick would evaluate. The second is a step at a ladder end that meets the saturated change counter. The bench provokes the first by changing the thresholds on the falling edge just before a `seq_tick` that completes the divider count. It provokes the second by sweeping the ladder twice so that the fifth change arrives with the counter already at 4. A behavioural model, advanced on every rising edge, judges both cases: it must see the gain hold with `cfg_err` set, and it must see the counter stay at 4 while the index still moves.

// File: rtl/agc_stepper.sv
module agc_stepper #(
  parameter int SET_W  = 8,
  parameter int DIV_W  = 6,
  parameter int CODE_W = 7,
  parameter int PWR_W  = 10,
  parameter int MIN_GAP = 30
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    seq_tick,
  input  logic [DIV_W-1:0]        agc_div,
  input  logic [SET_W-1:0]        settle_ticks,
  input  logic                    agc_en,
  input  logic [1:0]              man_lna,
  input  logic [1:0]              man_flt,
  input  logic [CODE_W-1:0]       thr_lo,
  input  logic [CODE_W-1:0]       thr_hi,
  input  logic [CODE_W-1:0]       rssi_code,
  output logic [1:0]              lna_gain,
  output logic [1:0]              flt_gain,
  output logic                    settled,
  output logic                    cfg_err,
  output logic [2:0]              step_count,
  output logic signed [PWR_W-1:0] power_hdb
);
  localparam logic [2:0] LAST = 3'd4;
  localparam logic [1:0] G_HI = 2'b10, G_MD = 2'b01, G_LO = 2'b00;

  logic [2:0]       idx_q, cnt_q;
  logic [SET_W-1:0] wait_q;
  logic [DIV_W-1:0] div_q;
  logic             set_q;
  logic [1:0]       lad_lna, lad_flt;
  logic [6:0]       lad_corr, man_corr;

  wire [DIV_W-1:0] div_eff = (agc_div == '0) ? DIV_W'(1) : agc_div;
  wire upd = agc_en && seq_tick && (div_q >= div_eff - DIV_W'(1));
  wire signed [CODE_W+1:0] gap = $signed({2'b00, thr_hi}) - $signed({2'b00, thr_lo});
  assign cfg_err = (gap <= MIN_GAP);

  wire go_up = (rssi_code < thr_lo) && (idx_q != 3'd0);
  wire go_dn = (rssi_code > thr_hi) && (idx_q != LAST);
  wire eval  = upd && (wait_q == '0) && !cfg_err;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx_q <= '0; cnt_q <= '0; wait_q <= '0; div_q <= '0; set_q <= 1'b0;
    end else if (!agc_en) begin
      idx_q <= '0; cnt_q <= '0; wait_q <= '0; div_q <= '0; set_q <= 1'b0;
    end else begin
      if (seq_tick) div_q <= upd ? '0 : div_q + DIV_W'(1);
      if (upd && wait_q != '0) wait_q <= wait_q - SET_W'(1);
      if (eval) begin
        if (go_up || go_dn) begin
          idx_q  <= go_up ? idx_q - 3'd1 : idx_q + 3'd1;
          wait_q <= settle_ticks;
          set_q  <= 1'b0;
          if (cnt_q != LAST) cnt_q <= cnt_q + 3'd1;
        end else begin
          set_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    case (idx_q)
      3'd0:    begin lad_lna = G_HI; lad_flt = G_HI; lad_corr = 7'd0;  end
      3'd1:    begin lad_lna = G_MD; lad_flt = G_HI; lad_corr = 7'd24; end
      3'd2:    begin lad_lna = G_MD; lad_flt = G_MD; lad_corr = 7'd38; end
      3'd3:    begin lad_lna = G_MD; lad_flt = G_LO; lad_corr = 7'd58; end
      default: begin lad_lna = G_LO; lad_flt = G_LO; lad_corr = 7'd86; end
    endcase
  end

  always_comb begin
    case ({man_lna, man_flt})
      {G_MD, G_HI}: man_corr = 7'd24;
      {G_MD, G_MD}: man_corr = 7'd38;
      {G_MD, G_LO}: man_corr = 7'd58;
      {G_LO, G_LO}: man_corr = 7'd86;
      default:      man_corr = 7'd0;
    endcase
  end

  wire [6:0] corr = agc_en ? lad_corr : man_corr;

  assign lna_gain   = agc_en ? lad_lna : man_lna;
  assign flt_gain   = agc_en ? lad_flt : man_flt;
  assign settled    = set_q;
  assign step_count = cnt_q;
  assign power_hdb  = $signed(PWR_W'(rssi_code) + PWR_W'(corr) - PWR_W'(260));
endmodule

module agc_stepper_chk (
  input logic                clk,
  input logic                rst_n,
  input logic                agc_en,
  input logic                cfg_err,
  input logic [1:0]          lna_gain,
  input logic [1:0]          flt_gain,
  input logic                settled,
  input logic [2:0]          step_count,
  input logic signed [9:0]   power_hdb
);
  wire [3:0] pair = {lna_gain, flt_gain};

  assert_reset_state_R1: assert property (@(posedge clk)
    $rose(rst_n) |-> (pair == 4'b1010 && !settled && step_count == 3'd0));

  assert_on_ladder_R2: assert property (@(posedge clk) disable iff (!rst_n)
    agc_en |-> (pair == 4'b1010 || pair == 4'b0110 || pair == 4'b0101 ||
                pair == 4'b0100 || pair == 4'b0000));

  assert_settle_no_move_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(settled) |-> $stable(pair));

  assert_cfg_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (agc_en && cfg_err) |=> (!agc_en || pair == $past(pair)));

  assert_power_span_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (power_hdb >= -10'sd260 && power_hdb <= -10'sd47));

  assert_count_cap_R10: assert property (@(posedge clk) disable iff (!rst_n)
    step_count <= 3'd4);
endmodule

bind agc_stepper agc_stepper_chk u_chk (
  .clk(clk), .rst_n(rst_n), .agc_en(agc_en), .cfg_err(cfg_err),
  .lna_gain(lna_gain), .flt_gain(flt_gain), .settled(settled),
  .step_count(step_count), .power_hdb(power_hdb)
);

// File: tb/tb_agc_stepper.sv
module tb_agc_stepper;
  logic clk = 0, rst_n = 0, seq_tick = 0, agc_en = 0;
  logic [5:0] agc_div = 6'd1;
  logic [7:0] settle_ticks = 8'd0;
  logic [1:0] man_lna = 2'b10, man_flt = 2'b10;
  logic [6:0] thr_lo = 7'd30, thr_hi = 7'd70, rssi_code = 7'd50;
  logic [1:0] lna_gain, flt_gain;
  logic settled, cfg_err;
  logic [2:0] step_count;
  logic signed [9:0] power_hdb;

  int total = 0, bad = 0, cycles = 0;
  string phase = "R1 reset";
  int m_idx = 0, m_wait = 0, m_div = 0, m_set = 0, m_cnt = 0;

  agc_stepper dut (.*);

  always #10 clk = ~clk;

  function automatic int lad_pair(input int i);
    case (i)
      0: return 'b1010; 1: return 'b0110; 2: return 'b0101;
      3: return 'b0100; default: return 'b0000;
    endcase
  endfunction
  function automatic int lad_corr(input int i);
    case (i) 0: return 0; 1: return 24; 2: return 38; 3: return 58; default: return 86; endcase
  endfunction
  function automatic int pair_corr(input int p);
    for (int i = 0; i < 5; i++) if (lad_pair(i) == p) return lad_corr(i);
    return 0;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n || !agc_en) begin
      m_idx = 0; m_wait = 0; m_div = 0; m_set = 0; m_cnt = 0;
    end else begin
      int eff; bit up; bit err;
      eff = (agc_div == 0) ? 1 : int'(agc_div);
      up  = seq_tick && (m_div >= eff - 1);
      err = (int'(thr_hi) - int'(thr_lo)) <= 30;
      if (seq_tick) m_div = up ? 0 : m_div + 1;
      if (up) begin
        if (m_wait > 0) m_wait--;
        else if (!err) begin
          if (int'(rssi_code) < int'(thr_lo) && m_idx > 0) begin
            m_idx--; m_wait = settle_ticks; m_set = 0; if (m_cnt < 4) m_cnt++;
          end else if (int'(rssi_code) > int'(thr_hi) && m_idx < 4) begin
            m_idx++; m_wait = settle_ticks; m_set = 0; if (m_cnt < 4) m_cnt++;
          end else m_set = 1;
        end
      end
    end
  end

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s [%s] actual=%0d expected=%0d", tag, phase, act, exp);
    end
  endtask

  task automatic compare();
    int p, c;
    p = agc_en ? lad_pair(m_idx) : int'({man_lna, man_flt});
    c = agc_en ? lad_corr(m_idx) : pair_corr(int'({man_lna, man_flt}));
    chk("R3 gain pair", int'({lna_gain, flt_gain}), p);
    chk("R4 settled", int'(settled), m_set);
    chk("R7 cfg_err", int'(cfg_err), ((int'(thr_hi) - int'(thr_lo)) <= 30) ? 1 : 0);
    chk("R8 power", int'(power_hdb), int'(rssi_code) + c - 260);
    chk("R10 count", int'(step_count), m_cnt);
  endtask

  task automatic run(input int n, input bit tick_always);
    for (int i = 0; i < n; i++) begin
      @(negedge clk);
      compare();
      seq_tick = tick_always ? 1'b1 : 1'($urandom_range(0, 1));
    end
  endtask

  initial begin
    void'($urandom(7));
    @(negedge clk);
    chk("R1 reset gain", int'({lna_gain, flt_gain}), 'b1010);
    chk("R1 reset count", int'(step_count), 0);
    rst_n = 1; agc_en = 1;
    @(negedge clk);
    chk("R1 after release", int'({lna_gain, flt_gain, settled}), 'b10100);

    phase = "R4 weak at max"; rssi_code = 7'd10; settle_ticks = 8'd2;
    run(6, 1);
    chk("R4 settled at max", int'(settled), 1);

    phase = "R2 R5 sweep down"; rssi_code = 7'd100;
    run(30, 1);
    chk("R2 bottom rung", int'({lna_gain, flt_gain}), 'b0000);
    chk("R10 count four", int'(step_count), 4);

    phase = "R10 sweep up saturate"; rssi_code = 7'd5;
    run(30, 1);
    chk("R10 still four", int'(step_count), 4);

    phase = "R6 divider 13"; agc_div = 6'd13; rssi_code = 7'd120; settle_ticks = 8'd1;
    run(200, 1);
    phase = "R6 divider zero"; agc_div = 6'd0; rssi_code = 7'd3;
    run(40, 0);

    phase = "R7 gap thirty"; agc_div = 6'd2; thr_lo = 7'd40; thr_hi = 7'd70; rssi_code = 7'd120;
    run(40, 1);
    phase = "R7 inverted"; thr_lo = 7'd90; thr_hi = 7'd20;
    run(20, 1);
    thr_lo = 7'd30; thr_hi = 7'd70;

    phase = "R9 manual";
    agc_en = 0;
    for (int p = 0; p < 16; p++) begin
      man_lna = 2'(p >> 2); man_flt = 2'(p);
      rssi_code = 7'(p * 7);
      run(2, 1);
    end
    agc_en = 1; rssi_code = 7'd100;
    @(negedge clk);
    chk("R9 restart max gain", int'({lna_gain, flt_gain}), 'b1010);
    chk("R9 restart count", int'(step_count), 0);

    phase = "R3 R5 R7 random";
    for (int k = 0; k < 300; k++) begin
      agc_div = 6'($urandom_range(0, 4));
      settle_ticks = 8'($urandom_range(0, 3));
      rssi_code = 7'($urandom_range(0, 127));
      if ($urandom_range(0, 7) == 0) thr_hi = 7'(int'(thr_lo) + $urandom_range(20, 40));
      else begin thr_lo = 7'd30; thr_hi = 7'd70; end
      agc_en = ($urandom_range(0, 31) != 0);
      run(int'($urandom_range(1, 8)), 0);
    end

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > 150000) begin
      bad++; total++;
      $display("FAIL watchdog [%s] actual=%0d expected=%0d", phase, cycles, 150000);
      $display("test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end
endmodule